// File: doc/BRIEF.md
# Reference Oscillator Seconds Counter

This block keeps a 64-bit count of elapsed seconds, timed by an external reference oscillator that runs with no fixed phase relation to the system clock. The oscillator input passes through a chain of synchronizer flops, and its rising edges are turned into pulses that last one system clock cycle. A divider counts these pulses and issues a one-second tick each time the count reaches a divide constant. The host sets this constant to the measured frequency of the oscillator, so that a steady frequency error is calibrated out. Each tick adds one to the epoch register.

The host can write a new epoch value at any time and reads the current value over a parallel output. A write also restarts the divider, so the first second after a write is a full second. The system clock must be fast enough that each high phase and each low phase of the reference spans at least two system clock periods. The reference must be held low while reset is asserted.

Top module: `epoch_timekeeper`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `epoch` is zero and `edge_pulse` and `sec_tick` are low.
- R2: Every rising edge of `ref_osc` produces exactly one `edge_pulse`, high for exactly one clock cycle. This holds even when the edge falls on a rising clock edge. Falling edges produce no pulse.
- R3: `sec_tick` is high only together with `edge_pulse`, for one cycle. It fires on the pulse that brings the number of pulses since the last tick or load to `div_const`. The count then restarts from zero, so no pulse is lost or counted twice at the wrap.
- R4: `div_const` is a run-time input that sets the pulses per second to any calibrated value. The values 0 and 1 both give one tick per pulse.
- R5: On a tick with no load, `epoch` increases by exactly one on the next clock edge. Carries pass through all 64 bits, so the upper half never rolls back to zero. With neither a tick nor a load, `epoch` holds its value.
- R6: A cycle with `load_en` high sets `epoch` to `load_val` on the next edge, and counting continues from that value.
- R7: When `load_en` and a tick occur in the same cycle, the loaded value wins and the tick is not added.
- R8: A load clears the divider count. The first tick after a load needs a full `div_const` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_osc | input | 1 | Asynchronous reference oscillator |
| div_const | input | DIV_W | Calibrated pulses per second |
| load_en | input | 1 | Write strobe for the epoch |
| load_val | input | 64 | Epoch value to write |
| epoch | output | 64 | Seconds count |
| edge_pulse | output | 1 | One-cycle pulse per reference rising edge |
| sec_tick | output | 1 | One-cycle pulse per elapsed second |

## Verification
The hardest case to reach is a write that lands in the very cycle a tick fires. The bench sets the divide constant to one so that every pulse is a tick. It then watches `edge_pulse` at the falling clock edge and raises `load_en` at once, which aligns the two events.

The other hard case is a reference edge that coincides with a system clock edge. The bench produces it by changing the reference directly on clock edges, mixed in among jittered edges. It then compares the number of pulses against an independent count of the reference's rising edges.

// File: rtl/epoch_pkg.sv
package epoch_pkg;
    localparam int EPOCH_W = 64;
    typedef logic [EPOCH_W-1:0] epoch_t;

    typedef struct packed {
        logic pulse;
        logic tick;
    } tk_evt_t;

    function automatic epoch_t epoch_next(input epoch_t cur, input logic ld,
                                          input epoch_t ldv, input logic tk);
        if (ld)      return ldv;
        else if (tk) return cur + epoch_t'(1);
        else         return cur;
    endfunction
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
    parameter int SYNC_STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic rise_pulse
);
    localparam int CHAIN_W = SYNC_STAGES + 1;
    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= ref_in;
    end

    genvar g;
    generate
        for (g = 1; g < CHAIN_W; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // compare two settled stages only; raw input never feeds the detector
    assign rise_pulse = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/tick_divider.sv
module tick_divider
    import epoch_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse,
    input  logic             clear,
    input  logic [DIV_W-1:0] div_const,
    output tk_evt_t          evt
);
    localparam int CW = DIV_W + 1;
    logic [DIV_W-1:0] cnt;
    logic             last;

    assign last = ({1'b0, cnt} + CW'(1)) >= {1'b0, div_const};

    always_ff @(posedge clk) begin
        if (rst || clear)   cnt <= '0;
        else if (pulse) begin
            if (last)       cnt <= '0;
            else            cnt <= cnt + DIV_W'(1);
        end
    end

    assign evt.pulse = pulse;
    assign evt.tick  = pulse & last;
endmodule

// File: rtl/epoch_counter.sv
module epoch_counter
    import epoch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   load_en,
    input  epoch_t load_val,
    output epoch_t value
);
    always_ff @(posedge clk) begin
        if (rst) value <= '0;
        else     value <= epoch_next(value, load_en, load_val, tick);
    end
endmodule

// File: rtl/epoch_timekeeper.sv
module epoch_timekeeper
    import epoch_pkg::*;
#(
    parameter int DIV_W       = 32,
    parameter int SYNC_STAGES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_osc,
    input  logic [DIV_W-1:0] div_const,
    input  logic             load_en,
    input  logic [63:0]      load_val,
    output logic [63:0]      epoch,
    output logic             edge_pulse,
    output logic             sec_tick
);
    logic    rise;
    tk_evt_t evt;

    ref_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ref_in(ref_osc), .rise_pulse(rise)
    );

    tick_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .pulse(rise), .clear(load_en),
        .div_const(div_const), .evt(evt)
    );

    epoch_counter u_epoch (
        .clk(clk), .rst(rst), .tick(evt.tick), .load_en(load_en),
        .load_val(load_val), .value(epoch)
    );

    assign edge_pulse = evt.pulse;
    assign sec_tick   = evt.tick;
endmodule

// File: rtl/epoch_timekeeper_chk.sv
module epoch_timekeeper_chk #(
    parameter int DIV_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [DIV_W-1:0] div_const,
    input logic             load_en,
    input logic [63:0]      load_val,
    input logic [63:0]      epoch,
    input logic             edge_pulse,
    input logic             sec_tick
);
    logic [DIV_W-1:0] seen;
    logic             due;

    always_ff @(posedge clk) begin
        if (rst || load_en)  seen <= '0;
        else if (sec_tick)   seen <= '0;
        else if (edge_pulse) seen <= seen + DIV_W'(1);
    end

    assign due = (div_const != '0) && (seen == div_const - DIV_W'(1));

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |=> !edge_pulse);
    p_tick_with_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> edge_pulse);
    p_no_early_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && div_const != '0) |-> due);
    p_tick_when_due_r8: assert property (@(posedge clk) disable iff (rst)
        (edge_pulse && due) |-> sec_tick);
    p_epoch_step_r5: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !load_en) |=> epoch == $past(epoch) + 64'd1);
    p_epoch_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !load_en) |=> $stable(epoch));
    p_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
        load_en |=> epoch == $past(load_val));
endmodule

bind epoch_timekeeper epoch_timekeeper_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .div_const(div_const), .load_en(load_en),
    .load_val(load_val), .epoch(epoch), .edge_pulse(edge_pulse),
    .sec_tick(sec_tick)
);

// File: tb/sim_epoch_timekeeper.sv
`timescale 1ns/1ps
module sim_epoch_timekeeper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_osc = 1'b0;
    logic [31:0] div_const = 32'd8;
    logic        load_en = 1'b0;
    logic [63:0] load_val = '0;
    logic [63:0] epoch;
    logic        edge_pulse, sec_tick;

    int total = 0;
    int bad = 0;
    int rises = 0;
    int pulses = 0;
    int ticks = 0;

    epoch_timekeeper u0 (
        .clk(clk), .rst(rst), .ref_osc(ref_osc), .div_const(div_const),
        .load_en(load_en), .load_val(load_val), .epoch(epoch),
        .edge_pulse(edge_pulse), .sec_tick(sec_tick)
    );

    always #2.5 clk = ~clk;

    always @(posedge ref_osc) rises++;
    always @(negedge clk) begin
        if (!rst && edge_pulse) pulses++;
        if (!rst && sec_tick)   ticks++;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    // jittered edges; every third rising edge lands on a clock edge
    task automatic drive_edges(input int n);
        for (int i = 0; i < n; i++) begin
            #($urandom_range(12, 30));
            if (i % 3 == 2) @(posedge clk);
            ref_osc = 1'b1;
            #($urandom_range(12, 30));
            if (i % 4 == 1) @(posedge clk);
            ref_osc = 1'b0;
        end
        settle();
    endtask

    task automatic do_load(input logic [63:0] v);
        @(negedge clk);
        load_en = 1'b1;
        load_val = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 epoch in reset", epoch, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 epoch after reset", epoch, 64'd0);
        check("R1 pulse after reset", {63'd0, edge_pulse}, 64'd0);
        check("R1 tick after reset", {63'd0, sec_tick}, 64'd0);
    endtask

    task automatic t_edges();
        int r0, p0, k0;
        div_const = 32'd8;
        do_load(64'd0);
        r0 = rises; p0 = pulses; k0 = ticks;
        drive_edges(40);
        check("R2 pulses vs rising edges", 64'(pulses - p0), 64'(rises - r0));
        check("R2 rising edges seen", 64'(rises - r0), 64'd40);
        check("R3 ticks for 40 pulses at 8", 64'(ticks - k0), 64'd5);
        check("R5 epoch after 5 seconds", epoch, 64'd5);
        drive_edges(7);
        check("R3 no tick before full count", epoch, 64'd5);
        drive_edges(1);
        check("R3 tick on eighth pulse", epoch, 64'd6);
    endtask

    task automatic t_calib();
        div_const = 32'd5;
        do_load(64'd0);
        drive_edges(23);
        check("R4 calibrated 5, 23 pulses", epoch, 64'd4);
        drive_edges(2);
        check("R4 calibrated 5, 25 pulses", epoch, 64'd5);
    endtask

    task automatic t_unity();
        div_const = 32'd1;
        do_load(64'd100);
        drive_edges(6);
        check("R4 divide by one", epoch, 64'd106);
        div_const = 32'd0;
        drive_edges(3);
        check("R4 divide by zero", epoch, 64'd109);
    endtask

    task automatic t_carry();
        div_const = 32'd2;
        do_load(64'h0000_0001_FFFF_FFFE);
        check("R6 load value", epoch, 64'h0000_0001_FFFF_FFFE);
        drive_edges(6);
        check("R5 carry across bit 32", epoch, 64'h0000_0002_0000_0001);
        do_load(64'hFFFF_FFFF_0000_0010);
        drive_edges(4);
        check("R6 continue from load", epoch, 64'hFFFF_FFFF_0000_0012);
    endtask

    task automatic t_phase();
        div_const = 32'd4;
        do_load(64'd0);
        drive_edges(3);
        do_load(64'd500);
        drive_edges(3);
        check("R8 phase cleared by load", epoch, 64'd500);
        drive_edges(1);
        check("R8 full second after load", epoch, 64'd501);
    endtask

    task automatic t_collide();
        int k0;
        div_const = 32'd1;
        do_load(64'd0);
        k0 = ticks;
        fork
            begin
                #13 ref_osc = 1'b1;
                #25 ref_osc = 1'b0;
            end
            begin
                do @(negedge clk); while (!edge_pulse);
                load_en = 1'b1;
                load_val = 64'd777;
                @(negedge clk);
                load_en = 1'b0;
            end
        join
        settle();
        check("R7 tick occurred with load", 64'(ticks - k0), 64'd1);
        check("R7 load overrides tick", epoch, 64'd777);
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_edges();
        t_calib();
        t_unity();
        t_carry();
        t_phase();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule